// File: doc/BRIEF.md
# Bus Address Decoder with Boot Overlay

This block sits beside a 68000-style processor with a 24-bit address bus and turns each bus cycle into exactly one chip select. The select targets chip RAM, the boot ROM, one of two peripheral interface adapters, the custom register block or the expansion space. For every cycle that reaches a mapped target, the block answers with an active-low data-acknowledge. A cycle to an address that nothing claims is ended with an active-low bus error after a fixed wait, so the processor never stalls forever.

At reset an overlay flag is set. While the flag is set, reads from the bottom of the map return boot ROM contents, so the processor can fetch its reset vectors. Writes to that region still reach chip RAM. Software clears the flag with a write to the first register of the odd-lane peripheral adapter, and after that chip RAM appears at address zero.

The two peripheral adapters share one 64 KB window and are told apart by byte lane. The odd-lane adapter answers on odd addresses and the even-lane adapter on even addresses. Each one also has an address bit that must be low for it to respond. Registers inside the window are spaced 256 bytes apart.

Top module: `bus_decoder`

## Requirements
- R1: After reset, with address strobe high, every select is low, `dtack_n` and `berr_n` are high, and the overlay flag is set.
- R2: While the overlay flag is set, a read below the chip RAM size selects ROM and not RAM. A write in the same region selects RAM.
- R3: Addresses $F80000 to $FFFFFF select ROM whether or not the overlay flag is set.
- R4: With the overlay clear, addresses below the chip RAM size select RAM. The size is 512 KB by default and 1 MB when `CHIP_RAM_KB` is 1024. Addresses from the size up to $1FFFFF are unmapped.
- R5: The odd-lane adapter is selected for addresses $BF0000 to $BFFFFF that have address bit 0 high and address bit 12 low (for example $BFE001 and $BFE101).
- R6: The even-lane adapter is selected for addresses $BF0000 to $BFFFFF that have address bit 0 low and address bit 13 low (for example $BFD000 and $BFD100). Other addresses in that window (for example $BFE000 and $BFD001) are unmapped.
- R7: Addresses $DFF000 to $DFFFFF select the custom register block. Addresses $200000 to $9FFFFF select expansion space.
- R8: Selects are driven only while `as_n` is low, and at most one select is high at any time.
- R9: When `as_n` and `ds_n` are both low on a mapped address, `dtack_n` goes low after the next rising clock edge. It returns high after the first rising edge at which `as_n` is high.
- R10: When an unmapped address is held with `as_n` low, `berr_n` goes low after the 64th rising edge. `berr_n` clears with the first edge at which `as_n` is high, and `dtack_n` stays high for that cycle.
- R11: A completed write to $BFE001 (odd-lane adapter, register index 0, address bits 11:8 zero) loads the overlay flag from `wr_data_lsb`. A write to any other register of that adapter leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 24 | Byte address of the bus cycle |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| rw | input | 1 | 1 for read, 0 for write |
| wr_data_lsb | input | 1 | Data bit 0 of a write cycle |
| sel_ram | output | 1 | Chip RAM select |
| sel_rom | output | 1 | Boot ROM select |
| sel_pia_a | output | 1 | Odd-lane peripheral adapter select |
| sel_pia_b | output | 1 | Even-lane peripheral adapter select |
| sel_regs | output | 1 | Custom register block select |
| sel_exp | output | 1 | Expansion space select |
| dtack_n | output | 1 | Data-acknowledge, active low |
| berr_n | output | 1 | Bus error, active low |

## Verification
The overlay flag is the only state that software can change. If it is wrong, the next read below the chip RAM size shows it at once, because the wrong select (ROM or RAM) rises in the same cycle as the address strobe. A wrong timeout counter shows up only at the end of an unmapped cycle, as a bus error that arrives early, late or never. A stuck acknowledge register shows up as `dtack_n` that is early, missing, or still low one edge after the strobe is released. The scoreboard therefore compares the select pattern, the kind of termination and its latency in clock edges for every cycle.

// File: rtl/bus_decoder.sv
module bus_decoder #(
  parameter int CHIP_RAM_KB = 512,
  parameter int TIMEOUT     = 64,
  parameter bit OVL_RESET   = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:0] addr,
  input  logic        as_n,
  input  logic        ds_n,
  input  logic        rw,
  input  logic        wr_data_lsb,
  output logic        sel_ram,
  output logic        sel_rom,
  output logic        sel_pia_a,
  output logic        sel_pia_b,
  output logic        sel_regs,
  output logic        sel_exp,
  output logic        dtack_n,
  output logic        berr_n
);
  localparam logic [31:0] RAM_BYTES = 32'(CHIP_RAM_KB) * 32'd1024;
  localparam int          CW        = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST    = CW'(TIMEOUT - 1);

  logic          ovl;
  logic          ack_q;
  logic          berr_q;
  logic [CW-1:0] wait_cnt;

  wire active  = ~as_n;
  wire in_ram  = {8'd0, addr} < RAM_BYTES;
  wire in_rom  = addr[23:19] == 5'b11111;
  wire in_pia  = addr[23:16] == 8'hBF;
  wire in_regs = addr[23:12] == 12'hDFF;
  wire in_exp  = (addr >= 24'h200000) && (addr < 24'hA00000);
  wire shadow  = ovl & rw;

  assign sel_ram   = active & in_ram & ~shadow;
  assign sel_rom   = active & (in_rom | (in_ram & shadow));
  assign sel_pia_a = active & in_pia &  addr[0] & ~addr[12];
  assign sel_pia_b = active & in_pia & ~addr[0] & ~addr[13];
  assign sel_regs  = active & in_regs;
  assign sel_exp   = active & in_exp;

  wire any_sel  = sel_ram | sel_rom | sel_pia_a | sel_pia_b | sel_regs | sel_exp;
  wire ovl_hit  = sel_pia_a & ~rw & ~ds_n & ~ack_q & (addr[11:8] == 4'd0);

  assign dtack_n = ~ack_q;
  assign berr_n  = ~berr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      ovl   <= OVL_RESET;
    end else begin
      ack_q <= any_sel & ~ds_n;
      if (ovl_hit) ovl <= wr_data_lsb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0;
      berr_q   <= 1'b0;
    end else if (as_n || any_sel) begin
      wait_cnt <= '0;
      berr_q   <= 1'b0;
    end else begin
      if (!berr_q) wait_cnt <= wait_cnt + 1'b1;
      if (wait_cnt == LAST) berr_q <= 1'b1;
    end
  end
endmodule

// File: rtl/bus_decoder_chk.sv
module bus_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [23:0] addr,
  input logic        as_n,
  input logic        ds_n,
  input logic        rw,
  input logic        sel_ram,
  input logic        sel_rom,
  input logic        sel_pia_a,
  input logic        sel_pia_b,
  input logic        sel_regs,
  input logic        sel_exp,
  input logic        dtack_n,
  input logic        berr_n
);
  wire [5:0] sels = {sel_exp, sel_regs, sel_pia_b, sel_pia_a, sel_rom, sel_ram};

  a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sels));
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n) as_n |-> (sels == 6'd0));
  a_r9_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && !ds_n && sels != 6'd0) |=> !dtack_n);
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n) as_n |=> dtack_n);
  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n) as_n |=> berr_n);
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n) !(!dtack_n && !berr_n));
  a_r3_rom: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && addr >= 24'hF80000) |-> sel_rom);
  a_r2_write_ram: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && !rw && addr < 24'h080000) |-> sel_ram);
endmodule

bind bus_decoder bus_decoder_chk u_chk (.*);

// File: tb/bus_decoder_bench.sv
module bus_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic        as_n = 1'b1, ds_n = 1'b1, rw = 1'b1, wr_data_lsb = 1'b0;
  logic        sel_ram, sel_rom, sel_pia_a, sel_pia_b, sel_regs, sel_exp, dtack_n, berr_n;
  logic        ram_1m, rom_1m, pa_1m, pb_1m, rg_1m, ex_1m, dt_1m, be_1m;

  always #4 clk = ~clk;

  bus_decoder u_bus_decoder (.clk, .rst_n, .addr, .as_n, .ds_n, .rw, .wr_data_lsb,
    .sel_ram, .sel_rom, .sel_pia_a, .sel_pia_b, .sel_regs, .sel_exp, .dtack_n, .berr_n);

  bus_decoder #(.CHIP_RAM_KB(1024)) u_bus_decoder_1m (.clk, .rst_n, .addr, .as_n, .ds_n, .rw,
    .wr_data_lsb, .sel_ram(ram_1m), .sel_rom(rom_1m), .sel_pia_a(pa_1m), .sel_pia_b(pb_1m),
    .sel_regs(rg_1m), .sel_exp(ex_1m), .dtack_n(dt_1m), .berr_n(be_1m));

  typedef struct {
    logic [5:0] sel;
    bit         is_berr;
    int         lat;
    string      tag;
  } item_t;

  item_t q[$];
  int vectors = 0, errors = 0, lat = 0, cycles = 0;
  bit taken = 0;

  wire [5:0] sels = {sel_exp, sel_regs, sel_pia_b, sel_pia_a, sel_rom, sel_ram};

  localparam logic [5:0] RAM = 6'b000001, ROM = 6'b000010, PA = 6'b000100,
                         PB = 6'b001000, REG = 6'b010000, EXP = 6'b100000, NONE = 6'b000000;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!as_n) begin
      lat++;
      if (!taken && (!dtack_n || !berr_n)) begin
        item_t it;
        taken = 1;
        if (q.size() == 0) check(0, "R9", "unexpected termination", 1, 0);
        else begin
          it = q.pop_front();
          check(sels == it.sel, it.tag, "select", sels, it.sel);
          check((!berr_n && dtack_n) == it.is_berr && (!dtack_n && berr_n) == !it.is_berr,
                it.tag, "termination dtack_n/berr_n", {dtack_n, berr_n}, it.is_berr ? 2 : 1);
          check(lat == it.lat, it.tag, "latency", lat, it.lat);
        end
      end
    end else begin
      lat = 0;
      taken = 0;
    end
  end

  task automatic cycle(input logic [23:0] a, input logic r, input logic d,
                       input logic [5:0] exp_sel, input bit ram1m, input string tag);
    item_t it;
    int guard = 0;
    it.sel = exp_sel;
    it.is_berr = (exp_sel == NONE);
    it.lat = it.is_berr ? 65 : 2;
    it.tag = tag;
    q.push_back(it);
    @(posedge clk); #1;
    addr = a; rw = r; wr_data_lsb = d; as_n = 1'b0; ds_n = 1'b0;
    while (!taken && guard < 200) begin @(posedge clk); guard++; end
    if (!taken) check(0, tag, "cycle never terminated", 0, 1);
    check(ram_1m == ram1m, "R4", "1MB instance sel_ram", ram_1m, ram1m);
    #1; as_n = 1'b1; ds_n = 1'b1;
    #1; check(sels == NONE, "R8", "selects after strobe release", sels, 0);
    @(posedge clk); #1;
    check(dtack_n && berr_n, it.is_berr ? "R10" : "R9", "release dtack_n/berr_n",
          {dtack_n, berr_n}, 3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(sels == NONE && dtack_n && berr_n, "R1", "reset outputs", {sels, dtack_n, berr_n}, 3);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(sels == NONE && dtack_n && berr_n, "R1", "idle outputs", {sels, dtack_n, berr_n}, 3);

    cycle(24'h000000, 1, 0, ROM, 0, "R1 R2 overlay read at zero");
    cycle(24'h07FFFE, 1, 0, ROM, 0, "R2 overlay read top of RAM");
    cycle(24'h000100, 0, 0, RAM, 1, "R2 overlay write goes to RAM");
    cycle(24'hF80000, 1, 0, ROM, 0, "R3 ROM base");
    cycle(24'hFFFFFE, 1, 0, ROM, 0, "R3 ROM top");
    cycle(24'hBFE001, 1, 0, PA,  0, "R5 odd adapter reg0");
    cycle(24'hBFE101, 1, 0, PA,  0, "R5 odd adapter reg1");
    cycle(24'hBFD000, 1, 0, PB,  0, "R6 even adapter reg0");
    cycle(24'hBFD100, 1, 0, PB,  0, "R6 even adapter reg1");
    cycle(24'hBFE000, 1, 0, NONE, 0, "R6 R10 even address in odd slot");
    cycle(24'hDFF000, 1, 0, REG, 0, "R7 custom regs base");
    cycle(24'hDFF1FE, 1, 0, REG, 0, "R7 custom regs inner");
    cycle(24'h200000, 1, 0, EXP, 0, "R7 expansion base");
    cycle(24'h9FFFFE, 1, 0, EXP, 0, "R7 expansion top");
    cycle(24'hBFE101, 0, 0, PA,  0, "R11 write other odd-adapter reg");
    cycle(24'h000000, 1, 0, ROM, 0, "R11 overlay unchanged");
    cycle(24'hBFE001, 0, 0, PA,  0, "R11 clear overlay");
    cycle(24'h000000, 1, 0, RAM, 1, "R4 RAM at zero after clear");
    cycle(24'h07FFFE, 1, 0, RAM, 1, "R4 RAM top 512K");
    cycle(24'hF80000, 1, 0, ROM, 0, "R3 ROM with overlay clear");
    cycle(24'h080000, 1, 0, NONE, 1, "R4 R10 above 512K unmapped");
    cycle(24'h1FFFFE, 1, 0, NONE, 0, "R4 R10 below 2M unmapped");
    cycle(24'hA00000, 1, 0, NONE, 0, "R10 gap unmapped");
    cycle(24'hBFE001, 0, 1, PA,  0, "R11 set overlay again");
    cycle(24'h000000, 1, 0, ROM, 0, "R11 R2 overlay restored");

    check(q.size() == 0, "R9", "scoreboard drained", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    check(0, "R10", "watchdog expired", cycles, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule